// File: doc/BRIEF.md
# UART Baud Tick Selector

This block produces the 16x oversampling strobe that paces a UART's transmitter and receiver. The strobe can come from three places. A dedicated down-counter divides the CPU clock by a 16-bit value taken from two byte-wide registers. An external timer supplies overflow pulses. A fixed prescaler divides the CPU clock by 1 or 2. The UART mode decides which of these sources is eligible. In the fixed-rate 11-bit mode the prescaler is always used. In the 10-bit mode and the variable-rate 11-bit mode a select bit picks either the dedicated divider or the timer. In the synchronous shift mode no strobe is produced.

A double-rate control bit affects two of the paths. On the timer path it decides whether every overflow pulse is passed on, or only every second one. On the fixed path it decides whether the strobe fires every cycle (bit rate = clock/16) or every other cycle (bit rate = clock/32). A write to either divisor byte restarts the dedicated divider from the new full count. This lets software change the rate without waiting for the old period to run out.

Top module: `uart_tick_select`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tick_o` is 0. Both divisor bytes reset to 0, so the effective divisor starts at 16.
- R2: With `uart_mode_i` = 0 (shift mode), `tick_o` stays 0 whatever the other inputs do.
- R3: With `uart_mode_i` = 1 or 3 and `src_sel_i` = 1, `tick_o` pulses once every D cycles. D is the divisor `{div_hi, div_lo}`, with the high byte in bits 15:8.
- R4: A divisor value below 16 (including 0) acts as 16.
- R5: A write to either divisor byte restarts the divider. The first tick after the write appears on `tick_o` exactly D clock edges after the write edge, where D is the new effective divisor.
- R6: With `uart_mode_i` = 1 or 3, `src_sel_i` = 0 and `dbl_rate_i` = 1, each `tmr_ovf_i` pulse produces one `tick_o` pulse in the following cycle.
- R7: With `uart_mode_i` = 1 or 3, `src_sel_i` = 0 and `dbl_rate_i` = 0, only every second `tmr_ovf_i` pulse produces a `tick_o` pulse.
- R8: With `uart_mode_i` = 2, `tick_o` is high every cycle when `dbl_rate_i` = 1, and every other cycle when `dbl_rate_i` = 0. `src_sel_i` and `tmr_ovf_i` have no effect in this mode.
- R9: Modes 1 and 3 use the source selection in the same way.
- R10: On the divider and timer paths, `tick_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU/oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_ovf_i | input | 1 | Single-cycle overflow strobe from the external timer |
| uart_mode_i | input | 2 | UART mode: 0 shift, 1 10-bit variable, 2 11-bit fixed, 3 11-bit variable |
| src_sel_i | input | 1 | Variable-rate source: 1 dedicated divider, 0 timer overflow |
| dbl_rate_i | input | 1 | Double-rate control for the timer and fixed paths |
| div_hi_i | input | 8 | Divisor high-byte write data |
| div_hi_we_i | input | 1 | Write strobe for the high byte |
| div_lo_i | input | 8 | Divisor low-byte write data |
| div_lo_we_i | input | 1 | Write strobe for the low byte |
| tick_o | output | 1 | Oversampling tick, registered |

## Verification
The timer-path assertion assumes that `tmr_ovf_i` is a single-cycle strobe, because two adjacent overflow pulses would legally produce adjacent ticks. The stimulus therefore spaces overflow pulses four cycles apart. The mode, select and double-rate inputs are held steady within each measurement window and change only between windows. The assertions tolerate a change in selection by conditioning on the selection in the cycle that fed the register.

// File: rtl/uart_tick_pkg.sv
// Package: shared mode encoding and default sizes for the baud tick selector.
// Assumes the mode field is two bits wide and decoded exactly as listed.
package uart_tick_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT = 2'd0,
        MODE_TEN   = 2'd1,
        MODE_FIXED = 2'd2,
        MODE_VAR11 = 2'd3
    } uart_mode_e;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned MIN_DIVISOR = 16;

endpackage

// File: rtl/ubrg_core.sv
// Module: dedicated baud divider. Holds two divisor bytes and counts down
// from the effective divisor (clamped to MIN_DIV). It emits a one-cycle
// strobe each time the counter reaches zero.
// Assumes: write strobes are synchronous to clk. A write restarts the count.
module ubrg_core #(
    parameter int unsigned REG_W   = 8,
    parameter int unsigned MIN_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] hi_i,
    input  logic             hi_we_i,
    input  logic [REG_W-1:0] lo_i,
    input  logic             lo_we_i,
    output logic             tick_o
);
    localparam int unsigned DIV_W = 2 * REG_W;
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

    logic [REG_W-1:0] hi_q, lo_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_cur, div_nxt, eff_cur, eff_nxt;

    // Raise any divisor below the minimum to the minimum.
    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
        return (d < MIN_V) ? MIN_V : d;
    endfunction

    // Form the present divisor and the divisor as it stands after this cycle's writes.
    always_comb begin
        div_cur = {hi_q, lo_q};
        div_nxt = {hi_we_i ? hi_i : hi_q, lo_we_i ? lo_i : lo_q};
        eff_cur = clamp_div(div_cur);
        eff_nxt = clamp_div(div_nxt);
    end

    // Store the divisor bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_we_i) hi_q <= hi_i;
            if (lo_we_i) lo_q <= lo_i;
        end
    end

    // Count down, reloading on zero or restarting on a divisor write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= MIN_V - DIV_W'(1);
        else if (hi_we_i || lo_we_i)
            cnt_q <= eff_nxt - DIV_W'(1);
        else if (cnt_q == '0)
            cnt_q <= eff_cur - DIV_W'(1);
        else
            cnt_q <= cnt_q - DIV_W'(1);
    end

    assign tick_o = (cnt_q == '0);

endmodule

// File: rtl/ovf_halver.sv
// Module: passes timer overflow pulses through, either all of them or every
// second one, according to the double-rate bit.
// Assumes: tmr_ovf_i is a single-cycle strobe. The phase flop tracks every pulse.
module ovf_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic dbl_i,
    output logic tick_o
);
    logic phase_q;

    // Toggle the phase on each overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)     phase_q <= 1'b0;
        else if (ovf_i) phase_q <= ~phase_q;
    end

    assign tick_o = ovf_i & (dbl_i | phase_q);

endmodule

// File: rtl/fixed_prescale.sv
// Module: fixed-rate strobe, high every cycle (dbl_i = 1) or every other cycle.
// Assumes: nothing about its inputs; the phase flop runs freely.
module fixed_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic dbl_i,
    output logic tick_o
);
    logic phase_q;

    // Free-running alternating phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign tick_o = dbl_i | phase_q;

endmodule

// File: rtl/uart_tick_select.sv
// Module: top of the UART baud tick selector. Runs the three tick sources in
// parallel, chooses one by UART mode and source select, and registers the
// result onto tick_o.
// Assumes: mode, select and double-rate inputs are synchronous to clk.
module uart_tick_select
    import uart_tick_pkg::*;
#(
    parameter int unsigned REG_W   = BYTE_W,
    parameter int unsigned MIN_DIV = MIN_DIVISOR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_ovf_i,
    input  logic [1:0]       uart_mode_i,
    input  logic             src_sel_i,
    input  logic             dbl_rate_i,
    input  logic [REG_W-1:0] div_hi_i,
    input  logic             div_hi_we_i,
    input  logic [REG_W-1:0] div_lo_i,
    input  logic             div_lo_we_i,
    output logic             tick_o
);
    logic       gen_tick, tmr_tick, fix_tick, sel_tick, tick_q;
    uart_mode_e mode;

    assign mode = uart_mode_e'(uart_mode_i);

    ubrg_core #(.REG_W(REG_W), .MIN_DIV(MIN_DIV)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_i    (div_hi_i),
        .hi_we_i (div_hi_we_i),
        .lo_i    (div_lo_i),
        .lo_we_i (div_lo_we_i),
        .tick_o  (gen_tick)
    );

    ovf_halver u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf_i  (tmr_ovf_i),
        .dbl_i  (dbl_rate_i),
        .tick_o (tmr_tick)
    );

    fixed_prescale u_fix (
        .clk    (clk),
        .rst_n  (rst_n),
        .dbl_i  (dbl_rate_i),
        .tick_o (fix_tick)
    );

    // Choose the tick source from the mode and the source select bit.
    always_comb begin
        case (mode)
            MODE_SHIFT: sel_tick = 1'b0;
            MODE_FIXED: sel_tick = fix_tick;
            default:    sel_tick = src_sel_i ? gen_tick : tmr_tick;
        endcase
    end

    // Register the selected tick onto the output.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= sel_tick;
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/uart_tick_select_chk.sv
// Module: assertion checker for uart_tick_select, bound to every instance.
// Assumes: tmr_ovf_i pulses are single-cycle (needed by the timer-path check).
module uart_tick_select_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_ovf_i,
    input logic [1:0] uart_mode_i,
    input logic       src_sel_i,
    input logic       dbl_rate_i,
    input logic       tick_o
);
    logic var_mode, gen_sel, tmr_sel, fix_half;

    assign var_mode = (uart_mode_i == 2'd1) || (uart_mode_i == 2'd3);
    assign gen_sel  = var_mode && src_sel_i;
    assign tmr_sel  = var_mode && !src_sel_i;
    assign fix_half = (uart_mode_i == 2'd2) && !dbl_rate_i;

    AST_SHIFT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_mode_i == 2'd0) |=> !tick_o); // R2

    AST_FIXED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((uart_mode_i == 2'd2) && dbl_rate_i) |=> tick_o); // R8

    AST_FIXED_HALF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(fix_half) && fix_half) |=> !tick_o); // R8

    AST_TMR_FROM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(tmr_sel)) |-> $past(tmr_ovf_i)); // R6

    AST_GEN_NO_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(gen_sel)) |=> (!tick_o || !$past(gen_sel))); // R10

endmodule

bind uart_tick_select uart_tick_select_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_ovf_i   (tmr_ovf_i),
    .uart_mode_i (uart_mode_i),
    .src_sel_i   (src_sel_i),
    .dbl_rate_i  (dbl_rate_i),
    .tick_o      (tick_o)
);

// File: tb/uart_tick_select_tb.sv
`timescale 1ns/1ps
module uart_tick_select_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_ovf_i = 1'b0;
    logic [1:0] uart_mode_i = 2'd0;
    logic       src_sel_i = 1'b0;
    logic       dbl_rate_i = 1'b0;
    logic [7:0] div_hi_i = 8'd0;
    logic       div_hi_we_i = 1'b0;
    logic [7:0] div_lo_i = 8'd0;
    logic       div_lo_we_i = 1'b0;
    logic       tick_o;

    int tests = 0;
    int fails = 0;

    localparam int WIN    = 96;
    localparam int OVF_P  = 4;
    localparam int NVEC   = 13;

    // {mode[27:26], src[25], dbl[24], divisor[23:8], expected ticks[7:0]}
    localparam logic [27:0] VEC [0:NVEC-1] = '{
        {2'd1, 1'b1, 1'b0, 16'h0010, 8'd6},
        {2'd1, 1'b1, 1'b1, 16'h0014, 8'd4},
        {2'd3, 1'b1, 1'b0, 16'h0018, 8'd4},
        {2'd3, 1'b1, 1'b0, 16'h0005, 8'd6},
        {2'd1, 1'b1, 1'b0, 16'h0000, 8'd6},
        {2'd1, 1'b0, 1'b1, 16'h0010, 8'd24},
        {2'd1, 1'b0, 1'b0, 16'h0010, 8'd12},
        {2'd3, 1'b0, 1'b0, 16'h0010, 8'd12},
        {2'd3, 1'b0, 1'b1, 16'h0010, 8'd24},
        {2'd2, 1'b1, 1'b1, 16'h0010, 8'd96},
        {2'd2, 1'b0, 1'b0, 16'h0010, 8'd48},
        {2'd0, 1'b1, 1'b1, 16'h0010, 8'd0},
        {2'd1, 1'b1, 1'b0, 16'h0030, 8'd2}
    };

    uart_tick_select u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_ovf_i   (tmr_ovf_i),
        .uart_mode_i (uart_mode_i),
        .src_sel_i   (src_sel_i),
        .dbl_rate_i  (dbl_rate_i),
        .div_hi_i    (div_hi_i),
        .div_hi_we_i (div_hi_we_i),
        .div_lo_i    (div_lo_i),
        .div_lo_we_i (div_lo_we_i),
        .tick_o      (tick_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write both divisor bytes, held for exactly one rising edge.
    task automatic write_div(input logic [15:0] d, input logic whi, input logic wlo);
        @(negedge clk);
        div_hi_i = d[15:8];
        div_lo_i = d[7:0];
        div_hi_we_i = whi;
        div_lo_we_i = wlo;
        @(negedge clk);
        div_hi_we_i = 1'b0;
        div_lo_we_i = 1'b0;
    endtask

    // Write, then count the edges until the first tick (R5 timing).
    task automatic write_and_time(input logic [15:0] d, input logic whi, input logic wlo,
                                  output int k);
        @(negedge clk);
        div_hi_i = d[15:8];
        div_lo_i = d[7:0];
        div_hi_we_i = whi;
        div_lo_we_i = wlo;
        @(posedge clk);
        #1;
        div_hi_we_i = 1'b0;
        div_lo_we_i = 1'b0;
        k = 0;
        for (int n = 0; n < 400; n++) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (tick_o) break;
        end
    endtask

    function automatic string tag_of(input logic [1:0] m, input logic s,
                                     input logic d, input logic [15:0] dv);
        if (m == 2'd0) return "R2";
        if (m == 2'd2) return "R8";
        if (!s) return d ? "R6/R9" : "R7/R9";
        if (dv < 16'd16) return "R4";
        return "R3/R9";
    endfunction

    initial begin
        #2_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int k;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 tick during reset", int'(tick_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tick after reset", int'(tick_o), 0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  m;
            logic        s, d;
            logic [15:0] dv;
            int          cnt, adj, prev;
            m  = VEC[v][27:26];
            s  = VEC[v][25];
            d  = VEC[v][24];
            dv = VEC[v][23:8];
            @(negedge clk);
            uart_mode_i = m;
            src_sel_i = s;
            dbl_rate_i = d;
            write_div(dv, 1'b1, 1'b1);
            cnt = 0;
            adj = 0;
            prev = 0;
            for (int i = 0; i <= WIN; i++) begin
                @(negedge clk);
                if (i > 0) begin
                    cnt += int'(tick_o);
                    if (prev == 1 && tick_o) adj++;
                    prev = int'(tick_o);
                end
                tmr_ovf_i = (i < WIN) && ((i % OVF_P) == OVF_P - 1);
            end
            tmr_ovf_i = 1'b0;
            check(tag_of(m, s, d, dv), cnt, int'(VEC[v][7:0]));
            if (m == 2'd1 || m == 2'd3)
                check("R10 adjacent ticks", adj, 0);
        end

        // Directed: restart timing (R5), clamp on restart (R4), high byte (R3)
        @(negedge clk);
        uart_mode_i = 2'd1;
        src_sel_i = 1'b1;
        dbl_rate_i = 1'b0;
        write_and_time(16'h0028, 1'b1, 1'b1, k);
        check("R5 first tick after full write", k, 40);
        repeat (10) @(negedge clk);
        write_and_time(16'h0012, 1'b0, 1'b1, k);
        check("R5 restart on low-byte write mid-count", k, 18);
        repeat (7) @(negedge clk);
        write_and_time(16'h0112, 1'b1, 1'b0, k);
        check("R5 R3 restart on high-byte write", k, 274);
        write_and_time(16'h0002, 1'b1, 1'b1, k);
        check("R4 clamped divisor after write", k, 16);

        // Directed: mode 0 ignores everything (R2)
        @(negedge clk);
        uart_mode_i = 2'd0;
        dbl_rate_i = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                tmr_ovf_i = (i % 2 == 0);
                @(negedge clk);
                seen += int'(tick_o);
            end
            tmr_ovf_i = 1'b0;
            check("R2 shift mode with overflow pulses", seen, 0);
        end

        // Directed: single ovf -> tick one cycle later (R6)
        @(negedge clk);
        uart_mode_i = 2'd3;
        src_sel_i = 1'b0;
        dbl_rate_i = 1'b1;
        repeat (3) @(negedge clk);
        tmr_ovf_i = 1'b1;
        @(negedge clk);
        tmr_ovf_i = 1'b0;
        check("R6 tick one cycle after overflow", int'(tick_o), 1);
        @(negedge clk);
        check("R6 tick single cycle", int'(tick_o), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule